// File: doc/BRIEF.md
# Linked-Descriptor Receive Engine

This block is the receive half of one DMA channel. It takes bytes from a client stream that carries an end-of-packet marker and places them into memory buffers described by a chain of linked data descriptors. A one-cycle start pulse gives it the address of the first descriptor and of a context word. From that point it fetches descriptors, fills buffers byte by byte through a word-wide memory master port, closes each buffer when it is full or when a packet ends, and writes the descriptor back. The written-back descriptor records where the fill actually stopped.

A descriptor is four 32-bit words at consecutive word addresses. Word 0 holds the next-descriptor pointer and word 1 the buffer start. Word 2 is the flag word, with bit 0 marking the last descriptor of the list, bit 4 requesting an interrupt and bit 11 set by the engine on packet end. Word 3 holds the buffer end, an exclusive byte address. When the last descriptor closes, the engine stops. It then marks the context as disabled by setting bit 15 of the context word and refuses further bytes until it is started again. Each raw interrupt event is reported as a one-cycle set mask on `irq_set_o`.

Top module: `rxd_engine`

## Requirements
- R1: A start pulse while the engine is idle reads descriptor words 0 to 3 from the given address, clears the channel end-of-list state and begins filling at the buffer start; `fill_ptr_o` then equals the buffer start.
- R2: Each accepted byte is written to the byte address in `fill_ptr_o`. The write uses word address `fill_ptr_o & ~3`, a single byte enable at bit `fill_ptr_o[1:0]` and the byte repeated in all four lanes. Bytes go to consecutive addresses.
- R3: When the fill pointer reaches the buffer end, the descriptor closes. Word 3 is written back with the fill pointer (equal to the old end) and word 2 is written back with bit 11 clear.
- R4: A byte that carries end-of-packet closes the descriptor after it is stored, even with space left. Word 3 is rewritten to the address after that byte and word 2 is written back with bit 11 set.
- R5: On close, a descriptor with flag bit 4 set raises raw interrupt bits 0 and 1, and an end-of-packet close raises bit 3. Both appear in the same single-cycle `irq_set_o` pulse. A close with neither condition gives no pulse.
- R6: A closing descriptor without bit 0 set is followed by a fetch of the descriptor at its next pointer, and the fill pointer restarts at the new buffer start.
- R7: When a descriptor with bit 0 set closes, `eol_o` goes high. The context word is then read and written back with bit 15 set and all other bits unchanged.
- R8: While `eol_o` is high, `in_ready_o` stays low and no byte reaches memory; a later start pulse resumes reception.
- R9: `in_ready_o` is low whenever a memory request is outstanding, and `fill_ptr_o` advances by one after each stored byte.
- R10: A memory request holds its address, write enable and data until `mem_ack_i` is seen; read data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured while idle |
| start_desc_i | input | 32 | Byte address of the first descriptor |
| start_ctx_i | input | 32 | Byte address of the context word |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_eop_i | input | 1 | Input byte ends a packet |
| in_ready_o | output | 1 | Engine accepts a byte this cycle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed; read data valid |
| mem_rdata_i | input | 32 | Read data |
| irq_set_o | output | 4 | One-cycle raw interrupt set mask |
| eol_o | output | 1 | Channel reached end of list |
| fill_ptr_o | output | 32 | Live buffer fill pointer |

## Verification
Two closing conditions can fall on the same byte: the last free byte of a buffer may also carry end-of-packet. Likewise, a descriptor interrupt and a packet-end interrupt can be due in the same close. The bench provokes both by sending a packet whose end lands exactly on a buffer end in a descriptor with its interrupt flag set. It expects a single close with the end word left at the buffer end, bit 11 set, and one pulse of mask 0xB, with no second close or empty write-back after it.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int FLG_EOL   = 0;
    localparam int FLG_INTR  = 4;
    localparam int FLG_INEOP = 11;
    localparam int CTX_DIS   = 15;
    localparam int IRQ_W     = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_RUN, S_WBYTE, S_WEND, S_WFLG, S_CRD, S_CWR
    } rxd_state_e;
endpackage

// File: rtl/rxd_lane.sv
module rxd_lane #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [7:0]    byte_i,
    output logic [AW-1:0] word_addr_o,
    output logic [3:0]    be_o,
    output logic [31:0]   wdata_o
);
    assign word_addr_o = {ptr_i[AW-1:2], 2'b00};
    assign be_o        = 4'b0001 << ptr_i[1:0];
    assign wdata_o     = {4{byte_i}};
endmodule

// File: rtl/rxd_close.sv
module rxd_close
    import rxd_pkg::*;
(
    input  logic             intr_i,
    input  logic             eop_i,
    output logic [IRQ_W-1:0] irq_o
);
    always_comb begin
        irq_o    = '0;
        irq_o[0] = intr_i;
        irq_o[1] = intr_i;
        irq_o[3] = eop_i;
    end
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    start_desc_i,
    input  logic [AW-1:0]    start_ctx_i,
    input  logic             in_valid_i,
    input  logic [7:0]       in_data_i,
    input  logic             in_eop_i,
    output logic             in_ready_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [3:0]       mem_be_o,
    output logic [31:0]      mem_wdata_o,
    input  logic             mem_ack_i,
    input  logic [31:0]      mem_rdata_i,
    output logic [IRQ_W-1:0] irq_set_o,
    output logic             eol_o,
    output logic [AW-1:0]    fill_ptr_o
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(4);

    typedef struct packed {
        rxd_state_e       state;
        logic [1:0]       widx;
        logic [AW-1:0]    desc;
        logic [AW-1:0]    ctx;
        logic [AW-1:0]    nxt;
        logic [AW-1:0]    bend;
        logic [31:0]      flags;
        logic [AW-1:0]    ptr;
        logic [7:0]       data;
        logic             eop;
        logic [31:0]      ctxw;
        logic             eol;
        logic [IRQ_W-1:0] irq;
    } rxd_reg_t;

    rxd_reg_t r_q, r_d;

    logic [AW-1:0]    lane_addr;
    logic [3:0]       lane_be;
    logic [31:0]      lane_wdata;
    logic [IRQ_W-1:0] irq_eop, irq_full;
    logic [AW-1:0]    ptr_inc;
    logic             accept;

    rxd_lane #(.AW(AW)) u_lane (
        .ptr_i       (r_q.ptr),
        .byte_i      (r_q.data),
        .word_addr_o (lane_addr),
        .be_o        (lane_be),
        .wdata_o     (lane_wdata)
    );

    rxd_close u_close_eop (
        .intr_i (r_q.flags[FLG_INTR]),
        .eop_i  (r_q.eop),
        .irq_o  (irq_eop)
    );

    rxd_close u_close_full (
        .intr_i (r_q.flags[FLG_INTR]),
        .eop_i  (1'b0),
        .irq_o  (irq_full)
    );

    assign ptr_inc    = r_q.ptr + AW'(1);
    assign in_ready_o = (r_q.state == S_RUN) && (r_q.ptr != r_q.bend);
    assign accept     = in_ready_o && in_valid_i;
    assign eol_o      = r_q.eol;
    assign fill_ptr_o = r_q.ptr;
    assign irq_set_o  = r_q.irq;

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_be_o    = 4'hF;
        mem_wdata_o = '0;
        case (r_q.state)
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.desc + (AW'(r_q.widx) << 2);
            end
            S_WBYTE: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = lane_addr;
                mem_be_o    = lane_be;
                mem_wdata_o = lane_wdata;
            end
            S_WEND: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.desc + 3 * WORD_BYTES;
                mem_wdata_o = 32'(r_q.ptr);
            end
            S_WFLG: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.desc + 2 * WORD_BYTES;
                mem_wdata_o = r_q.flags | (32'(r_q.eop) << FLG_INEOP);
            end
            S_CRD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.ctx;
            end
            S_CWR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.ctx;
                mem_wdata_o = r_q.ctxw;
            end
            default: ;
        endcase
    end

    always_comb begin
        r_d     = r_q;
        r_d.irq = '0;
        case (r_q.state)
            S_IDLE: begin
                if (start_i) begin
                    r_d.desc  = start_desc_i;
                    r_d.ctx   = start_ctx_i;
                    r_d.eol   = 1'b0;
                    r_d.widx  = 2'd0;
                    r_d.state = S_FETCH;
                end
            end
            S_FETCH: begin
                if (mem_ack_i) begin
                    case (r_q.widx)
                        2'd0:    r_d.nxt   = AW'(mem_rdata_i);
                        2'd1:    r_d.ptr   = AW'(mem_rdata_i);
                        2'd2:    r_d.flags = mem_rdata_i;
                        default: r_d.bend  = AW'(mem_rdata_i);
                    endcase
                    r_d.widx = r_q.widx + 2'd1;
                    if (r_q.widx == 2'd3) begin
                        r_d.eop   = 1'b0;
                        r_d.state = S_RUN;
                    end
                end
            end
            S_RUN: begin
                if (accept) begin
                    r_d.data  = in_data_i;
                    r_d.eop   = in_eop_i;
                    r_d.state = S_WBYTE;
                end else if (r_q.ptr == r_q.bend) begin
                    r_d.eop   = 1'b0;
                    r_d.irq   = irq_full;
                    r_d.state = S_WEND;
                end
            end
            S_WBYTE: begin
                if (mem_ack_i) begin
                    r_d.ptr = ptr_inc;
                    if (ptr_inc == r_q.bend || r_q.eop) begin
                        r_d.irq   = irq_eop;
                        r_d.state = S_WEND;
                    end else begin
                        r_d.state = S_RUN;
                    end
                end
            end
            S_WEND: begin
                if (mem_ack_i) r_d.state = S_WFLG;
            end
            S_WFLG: begin
                if (mem_ack_i) begin
                    if (r_q.flags[FLG_EOL]) begin
                        r_d.eol   = 1'b1;
                        r_d.state = S_CRD;
                    end else begin
                        r_d.desc  = r_q.nxt;
                        r_d.widx  = 2'd0;
                        r_d.state = S_FETCH;
                    end
                end
            end
            S_CRD: begin
                if (mem_ack_i) begin
                    r_d.ctxw  = mem_rdata_i | (32'd1 << CTX_DIS);
                    r_d.state = S_CWR;
                end
            end
            S_CWR: begin
                if (mem_ack_i) r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/rxd_engine_chk.sv
module rxd_engine_chk
    import rxd_pkg::*;
#(
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready_o,
    input logic             mem_req_o,
    input logic             mem_we_o,
    input logic [AW-1:0]    mem_addr_o,
    input logic [31:0]      mem_wdata_o,
    input logic             mem_ack_i,
    input logic [IRQ_W-1:0] irq_set_o,
    input logic             eol_o,
    input logic [AW-1:0]    fill_ptr_o
);
    a_r8_no_ready_at_eol: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |-> !in_ready_o);

    a_r9_no_ready_during_mem: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> !mem_req_o);

    a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o && $past(mem_req_o && mem_we_o && mem_ack_i) && $past(in_ready_o, 3))
        |-> (fill_ptr_o == $past(fill_ptr_o, 3) + AW'(1)));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=>
        (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    a_r5_irq_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set_o[0] == irq_set_o[1]) && !irq_set_o[2]);

    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set_o != '0) |=> (irq_set_o == '0));
endmodule

bind rxd_engine rxd_engine_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready_o  (in_ready_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .irq_set_o   (irq_set_o),
    .eol_o       (eol_o),
    .fill_ptr_o  (fill_ptr_o)
);

// File: tb/tb_rxd_engine.sv
module tb_rxd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_desc_i = '0;
    logic [31:0] start_ctx_i = '0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_data_i = '0;
    logic        in_eop_i = 1'b0;
    logic        in_ready_o;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o;
    logic [3:0]  mem_be_o;
    logic [31:0] mem_wdata_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic [3:0]  irq_set_o;
    logic        eol_o;
    logic [31:0] fill_ptr_o;

    int total = 0;
    int bad = 0;
    int byte_writes = 0;
    logic [31:0] mem [0:511];
    logic [39:0] exp_bytes [$];
    logic [3:0]  exp_irq [$];

    always #10 clk = ~clk;

    rxd_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_desc_i(start_desc_i),
        .start_ctx_i(start_ctx_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .in_eop_i(in_eop_i), .in_ready_o(in_ready_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .irq_set_o(irq_set_o), .eol_o(eol_o), .fill_ptr_o(fill_ptr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (mem_req_o && !mem_ack_i) begin
            mem_ack_i   <= 1'b1;
            mem_rdata_i <= mem[mem_addr_o[10:2]];
            if (mem_we_o)
                for (int b = 0; b < 4; b++)
                    if (mem_be_o[b]) mem[mem_addr_o[10:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
        end else begin
            mem_ack_i <= 1'b0;
        end
    end

    // monitor: byte writes and interrupt pulses against the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_req_o && mem_we_o && !mem_ack_i && mem_be_o != 4'hF) begin
            logic [39:0] e;
            int lane;
            byte_writes++;
            lane = 0;
            for (int b = 0; b < 4; b++) if (mem_be_o[b]) lane = b;
            if (exp_bytes.size() == 0) begin
                check("R8 unexpected byte write", mem_addr_o, 32'hFFFF_FFFF);
            end else begin
                e = exp_bytes.pop_front();
                check("R2 byte address", {mem_addr_o[31:2], 2'(lane)}, e[39:8]);
                check("R2 single lane", 32'($countones(mem_be_o)), 32'd1);
                check("R2 byte data", {24'd0, mem_wdata_o[8*lane +: 8]}, {24'd0, e[7:0]});
            end
        end
        if (rst_n && irq_set_o != 4'h0) begin
            if (exp_irq.size() == 0) check("R5 unexpected irq", {28'd0, irq_set_o}, 32'd0);
            else check("R5 irq mask", {28'd0, irq_set_o}, {28'd0, exp_irq.pop_front()});
        end
    end

    task automatic send(input logic [31:0] addr, input logic [7:0] d, input logic eop);
        logic ok;
        exp_bytes.push_back({addr, d});
        @(negedge clk);
        in_valid_i = 1'b1; in_data_i = d; in_eop_i = eop;
        forever begin
            ok = in_ready_o;
            @(negedge clk);
            if (ok) break;
        end
        in_valid_i = 1'b0; in_eop_i = 1'b0;
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!in_ready_o);
    endtask

    task automatic start(input logic [31:0] d, input logic [31:0] c);
        @(negedge clk);
        start_i = 1'b1; start_desc_i = d; start_ctx_i = c;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic put_desc(input int a, input logic [31:0] nx, input logic [31:0] bs,
                            input logic [31:0] fl, input logic [31:0] be);
        mem[a >> 2] = nx; mem[(a >> 2) + 1] = bs; mem[(a >> 2) + 2] = fl; mem[(a >> 2) + 3] = be;
    endtask

    initial begin
        int n;
        for (int i = 0; i < 512; i++) mem[i] = '0;
        put_desc(32'h100, 32'h140, 32'h400, 32'h0000_0010, 32'h404); // intr
        put_desc(32'h140, 32'h180, 32'h500, 32'h0000_0000, 32'h510);
        put_desc(32'h180, 32'h000, 32'h600, 32'h0000_0011, 32'h608); // eol+intr
        put_desc(32'h1C0, 32'h000, 32'h700, 32'h0000_0001, 32'h702); // eol only
        put_desc(32'h200, 32'h000, 32'h720, 32'h0000_0011, 32'h724); // eol+intr
        mem[32'h80 >> 2] = 32'h0000_0005;
        mem[32'h90 >> 2] = 32'h0000_7F00;

        repeat (3) @(negedge clk);
        check("R8 reset ready", {31'd0, in_ready_o}, 32'd0);
        check("R7 reset eol", {31'd0, eol_o}, 32'd0);
        check("R5 reset irq", {28'd0, irq_set_o}, 32'd0);
        check("R10 reset req", {31'd0, mem_req_o}, 32'd0);
        rst_n = 1'b1;

        start(32'h100, 32'h80);
        wait_ready();
        check("R1 fill starts at buffer start", fill_ptr_o, 32'h400);
        exp_irq.push_back(4'h3);
        for (int i = 0; i < 4; i++) send(32'h400 + i, 8'hA0 + 8'(i), 1'b0);
        wait_ready();
        check("R6 pointer at next buffer", fill_ptr_o, 32'h500);
        check("R3 end word kept on full close", mem[32'h10C >> 2], 32'h404);
        check("R3 no packet flag on full close", mem[32'h108 >> 2], 32'h0000_0010);

        send(32'h500, 8'h51, 1'b0);
        wait_ready();
        check("R9 pointer steps by one", fill_ptr_o, 32'h501);
        exp_irq.push_back(4'h8);
        for (int i = 1; i < 5; i++) send(32'h500 + i, 8'h50 + 8'(i), i == 4);
        wait_ready();
        check("R4 end word rewritten to fill point", mem[32'h14C >> 2], 32'h505);
        check("R4 packet flag set", mem[32'h148 >> 2], 32'h0000_0800);
        check("R6 third buffer start", fill_ptr_o, 32'h600);

        exp_irq.push_back(4'hB);
        for (int i = 0; i < 3; i++) send(32'h600 + i, 8'hC0 + 8'(i), i == 2);
        do @(negedge clk); while (!eol_o);
        repeat (8) @(negedge clk);
        check("R7 eol raised", {31'd0, eol_o}, 32'd1);
        check("R7 context disabled, rest kept", mem[32'h80 >> 2], 32'h0000_8005);
        check("R4 short fill end word", mem[32'h18C >> 2], 32'h603);
        check("R5 flags on last close", mem[32'h188 >> 2], 32'h0000_0811);

        n = byte_writes;
        @(negedge clk);
        in_valid_i = 1'b1; in_data_i = 8'hEE;
        repeat (10) begin
            @(negedge clk);
            check("R8 ready low at eol", {31'd0, in_ready_o}, 32'd0);
        end
        in_valid_i = 1'b0;
        check("R8 no byte stored at eol", 32'(byte_writes), 32'(n));

        // restart: full close with no interrupt flag gives no pulse
        start(32'h1C0, 32'h80);
        wait_ready();
        check("R8 restart clears eol", {31'd0, eol_o}, 32'd0);
        check("R1 restart buffer start", fill_ptr_o, 32'h700);
        send(32'h700, 8'h11, 1'b0);
        send(32'h701, 8'h22, 1'b0);
        do @(negedge clk); while (!eol_o);
        repeat (8) @(negedge clk);
        check("R5 no pulse without cause", 32'(exp_irq.size()), 32'd0);
        check("R3 flags without packet end", mem[32'h1C8 >> 2], 32'h0000_0001);
        check("R3 end word on full", mem[32'h1CC >> 2], 32'h702);

        // coincident close: packet end on the last free byte, intr set
        start(32'h200, 32'h90);
        wait_ready();
        exp_irq.push_back(4'hB);
        for (int i = 0; i < 4; i++) send(32'h720 + i, 8'h70 + 8'(i), i == 3);
        do @(negedge clk); while (!eol_o);
        repeat (8) @(negedge clk);
        check("R4 coincident end word", mem[32'h20C >> 2], 32'h724);
        check("R4 coincident packet flag", mem[32'h208 >> 2], 32'h0000_0811);
        check("R7 context bit set once", mem[32'h90 >> 2], 32'h0000_FF00);
        check("R5 all pulses seen", 32'(exp_irq.size()), 32'd0);
        check("R2 all bytes seen", 32'(exp_bytes.size()), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule